// File: doc/BRIEF.md
# Banked Address Decoder with Byte-Wide UART Page

This block sits between a 16-bit CPU load/store port and the memory system. It sorts each CPU address into one of four regions. The regions are banked general memory, a stack page, an I/O page and a vector page. For every access that goes to memory, it forms an extended address from a bank number and the CPU address.

The bank number comes from a bank-select register, but only for addresses below 0xFD00. The three top pages are always pinned to bank 0. Word accesses are big-endian: the byte at the lower address travels in bits 15:8. An access to the I/O page never reaches memory and is always handled as one byte, whatever size the CPU asked for.

Two UART registers sit at the bottom of the I/O page. A data register holds the received byte and launches transmit bytes. A status register reports whether a received byte is waiting and whether the transmitter can take a byte. On the far side of these registers are a simple byte source and byte sink.

Top module: `banked_addr_decoder`

## Requirements
- R1: `region` reports 0 for addresses 0x0000–0xFCFF, 1 for 0xFD00–0xFDFF, 2 for 0xFE00–0xFEFF and 3 for 0xFF00–0xFFFF.
- R2: `memAddr` is {bank, cpuAddr}; the bank field equals the bank register below 0xFD00 and is 0 from 0xFD00 upward.
- R3: The bank register resets to 0. When `bankWrEn` is high, the register loads `bankNew` at the clock edge, and `bankOld` shows the value held before that edge.
- R4: An access in the I/O page keeps `memReq` low, and a word read there returns a byte with bits 15:8 zero.
- R5: A memory word access drives `memWord`=1 and returns `memRdata` unchanged, with bits 15:8 being the lower-address byte. A memory byte access drives `memWord`=0, returns {0x00, memRdata[7:0]} and drives `memWdata` as {0x00, cpuWdata[7:0]}.
- R6: A read of 0xFE01 returns bit 0 = input ready, bit 1 = `txReady`, and all other bits 0.
- R7: When `rxValid` is high and input ready is low, `rxByte` is captured and input ready is set at the edge. While input ready is high, `rxValid` is ignored and the held byte is kept.
- R8: A read of 0xFE00 returns the held byte, and input ready clears at that edge.
- R9: A write of 0xFE00 while `txReady` is high raises `txValid` for one cycle after the edge, with `txByte` = cpuWdata[7:0]. A write while `txReady` is low is ignored and `txValid` stays low.
- R10: Any other I/O address reads as 0x0000, and writes to it raise no `txValid` and leave the UART status unchanged.
- R11: Outside the I/O page, `memReq` follows `cpuReq` and `memWe` equals cpuReq AND cpuWe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | CPU access valid this cycle |
| cpuWe | input | 1 | 1 = write, 0 = read |
| cpuWord | input | 1 | 1 = 16-bit access, 0 = 8-bit |
| cpuAddr | input | 16 | CPU byte address |
| cpuWdata | input | 16 | CPU write data |
| cpuRdata | output | 16 | Read data to CPU |
| bankWrEn | input | 1 | Load bank register this cycle |
| bankNew | input | BANK_W | New bank number |
| bankOld | output | BANK_W | Bank number currently held |
| region | output | 2 | Region code of cpuAddr |
| memReq | output | 1 | Memory access strobe |
| memWe | output | 1 | Memory write strobe |
| memWord | output | 1 | Memory access is 16-bit |
| memAddr | output | BANK_W+16 | Extended memory address |
| memWdata | output | 16 | Memory write data |
| memRdata | input | 16 | Memory read data |
| rxValid | input | 1 | Byte source offers a byte |
| rxByte | input | 8 | Offered byte |
| txReady | input | 1 | Byte sink can accept a byte |
| txValid | output | 1 | Byte sent to sink this cycle |
| txByte | output | 8 | Byte sent to sink |

## Verification
A wrong bank register is visible in the same cycle on the upper bits of `memAddr` for any low-memory access. A bad pinning shows as a nonzero bank field on stack or vector addresses. A stuck input-ready flag shows on the next status read: either as bit 0 staying set after a data read, or as a second offered byte being captured over the first. A wrong transmit state shows one cycle after the write, either as a `txValid` pulse that should not be there or as a wrong `txByte`.

// File: rtl/bmd_pkg.sv
package bmd_pkg;

  localparam int ADDR_W = 16;
  localparam int PAGE_W = 8;

  localparam logic [PAGE_W-1:0] STACK_PAGE = 8'hFD;
  localparam logic [PAGE_W-1:0] IO_PAGE    = 8'hFE;
  localparam logic [PAGE_W-1:0] VEC_PAGE   = 8'hFF;

  localparam logic [PAGE_W-1:0] UART_DATA_OFS = 8'h00;
  localparam logic [PAGE_W-1:0] UART_STAT_OFS = 8'h01;

  typedef enum logic [1:0] {
    RGN_GEN   = 2'd0,
    RGN_STACK = 2'd1,
    RGN_IO    = 2'd2,
    RGN_VEC   = 2'd3
  } region_e;

  typedef struct packed {
    region_e region;
    logic    memReq;
    logic    memWe;
    logic    memWord;
    logic    ioRd;
    logic    dataRd;
    logic    dataWr;
    logic    statRd;
  } strobe_t;

endpackage

// File: rtl/bmd_ctrl.sv
module bmd_ctrl
  import bmd_pkg::*;
(
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic              cpuWord,
  input  logic [ADDR_W-1:0] cpuAddr,
  output strobe_t           stb
);

  logic [PAGE_W-1:0] page;
  logic [PAGE_W-1:0] offset;
  logic              isIo;

  assign page   = cpuAddr[ADDR_W-1 -: PAGE_W];
  assign offset = cpuAddr[PAGE_W-1:0];
  assign isIo   = (page == IO_PAGE);

  always_comb begin
    stb = '0;
    if (page == VEC_PAGE)        stb.region = RGN_VEC;
    else if (isIo)               stb.region = RGN_IO;
    else if (page == STACK_PAGE) stb.region = RGN_STACK;
    else                         stb.region = RGN_GEN;

    // memory path: everything but the I/O page
    stb.memReq  = cpuReq && !isIo;
    stb.memWe   = cpuReq && !isIo && cpuWe;
    stb.memWord = cpuReq && !isIo && cpuWord;

    // I/O path: always byte sized
    stb.ioRd   = cpuReq && isIo && !cpuWe;
    stb.dataRd = stb.ioRd && (offset == UART_DATA_OFS);
    stb.statRd = stb.ioRd && (offset == UART_STAT_OFS);
    stb.dataWr = cpuReq && isIo && cpuWe && (offset == UART_DATA_OFS);
  end

endmodule

// File: rtl/bmd_datapath.sv
module bmd_datapath
  import bmd_pkg::*;
#(
  parameter int BANK_W = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  stb,
  input  logic [ADDR_W-1:0]        cpuAddr,
  input  logic [15:0]              cpuWdata,
  output logic [15:0]              cpuRdata,
  input  logic                     bankWrEn,
  input  logic [BANK_W-1:0]        bankNew,
  output logic [BANK_W-1:0]        bankOld,
  output logic [BANK_W+ADDR_W-1:0] memAddr,
  output logic [15:0]              memWdata,
  input  logic [15:0]              memRdata,
  input  logic                     rxValid,
  input  logic [7:0]               rxByte,
  input  logic                     txReady,
  output logic                     txValid,
  output logic [7:0]               txByte
);

  logic [BANK_W-1:0] bankQ;
  logic [BANK_W-1:0] bankUsed;
  logic              rxFull;
  logic [7:0]        rxData;
  logic [7:0]        ioByte;

  // bank select register
  always_ff @(posedge clk) begin
    if (!rstN)         bankQ <= '0;
    else if (bankWrEn) bankQ <= bankNew;
  end

  assign bankOld  = bankQ;
  assign bankUsed = (stb.region == RGN_GEN) ? bankQ : '0;
  assign memAddr  = {bankUsed, cpuAddr};
  assign memWdata = stb.memWord ? cpuWdata : {8'h00, cpuWdata[7:0]};

  // receive holding register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxFull <= 1'b0;
      rxData <= '0;
    end else if (!rxFull && rxValid) begin
      rxFull <= 1'b1;
      rxData <= rxByte;
    end else if (stb.dataRd) begin
      rxFull <= 1'b0;
    end
  end

  // transmit launch
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txValid <= 1'b0;
      txByte  <= '0;
    end else begin
      txValid <= stb.dataWr && txReady;
      if (stb.dataWr && txReady) txByte <= cpuWdata[7:0];
    end
  end

  always_comb begin
    if (stb.dataRd)      ioByte = rxData;
    else if (stb.statRd) ioByte = {6'b0, txReady, rxFull};
    else                 ioByte = 8'h00;
  end

  always_comb begin
    if (stb.ioRd)         cpuRdata = {8'h00, ioByte};
    else if (stb.memWord) cpuRdata = memRdata;
    else if (stb.memReq)  cpuRdata = {8'h00, memRdata[7:0]};
    else                  cpuRdata = 16'h0000;
  end

endmodule

// File: rtl/banked_addr_decoder.sv
module banked_addr_decoder
  import bmd_pkg::*;
#(
  parameter int BANK_W = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cpuReq,
  input  logic                     cpuWe,
  input  logic                     cpuWord,
  input  logic [15:0]              cpuAddr,
  input  logic [15:0]              cpuWdata,
  output logic [15:0]              cpuRdata,
  input  logic                     bankWrEn,
  input  logic [BANK_W-1:0]        bankNew,
  output logic [BANK_W-1:0]        bankOld,
  output logic [1:0]               region,
  output logic                     memReq,
  output logic                     memWe,
  output logic                     memWord,
  output logic [BANK_W+15:0]       memAddr,
  output logic [15:0]              memWdata,
  input  logic [15:0]              memRdata,
  input  logic                     rxValid,
  input  logic [7:0]               rxByte,
  input  logic                     txReady,
  output logic                     txValid,
  output logic [7:0]               txByte
);

  strobe_t stb;

  bmd_ctrl u_ctrl (
    .cpuReq (cpuReq),
    .cpuWe  (cpuWe),
    .cpuWord(cpuWord),
    .cpuAddr(cpuAddr),
    .stb    (stb)
  );

  bmd_datapath #(.BANK_W(BANK_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .cpuAddr (cpuAddr),
    .cpuWdata(cpuWdata),
    .cpuRdata(cpuRdata),
    .bankWrEn(bankWrEn),
    .bankNew (bankNew),
    .bankOld (bankOld),
    .memAddr (memAddr),
    .memWdata(memWdata),
    .memRdata(memRdata),
    .rxValid (rxValid),
    .rxByte  (rxByte),
    .txReady (txReady),
    .txValid (txValid),
    .txByte  (txByte)
  );

  assign region  = stb.region;
  assign memReq  = stb.memReq;
  assign memWe   = stb.memWe;
  assign memWord = stb.memWord;

endmodule

// File: rtl/banked_addr_decoder_chk.sv
module banked_addr_decoder_chk #(
  parameter int BANK_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuReq,
  input logic              cpuWe,
  input logic [15:0]       cpuAddr,
  input logic [15:0]       cpuRdata,
  input logic              bankWrEn,
  input logic [BANK_W-1:0] bankNew,
  input logic [BANK_W-1:0] bankOld,
  input logic [1:0]        region,
  input logic              memReq,
  input logic [BANK_W+15:0] memAddr,
  input logic              txReady,
  input logic              txValid
);

  // R1
  io_region_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuAddr[15:8] == 8'hFE) |-> (region == 2'd2));

  // R2
  top_bank_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuAddr[15:8] >= 8'hFD) |-> (memAddr[BANK_W+15:16] == '0));

  // R2
  low_bank_used_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuAddr[15:8] < 8'hFD) |-> (memAddr[BANK_W+15:16] == bankOld));

  // R3
  bank_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    bankWrEn |=> (bankOld == $past(bankNew)));

  // R4
  io_no_mem_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuAddr[15:8] == 8'hFE) |-> !memReq);

  // R4
  io_byte_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReq && !cpuWe && cpuAddr[15:8] == 8'hFE) |-> (cpuRdata[15:8] == 8'h00));

  // R9
  tx_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> $past(cpuReq && cpuWe && cpuAddr == 16'hFE00 && txReady));

endmodule

bind banked_addr_decoder banked_addr_decoder_chk #(.BANK_W(BANK_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .cpuReq  (cpuReq),
  .cpuWe   (cpuWe),
  .cpuAddr (cpuAddr),
  .cpuRdata(cpuRdata),
  .bankWrEn(bankWrEn),
  .bankNew (bankNew),
  .bankOld (bankOld),
  .region  (region),
  .memReq  (memReq),
  .memAddr (memAddr),
  .txReady (txReady),
  .txValid (txValid)
);

// File: tb/banked_addr_decoder_tb.sv
module banked_addr_decoder_tb;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int BANK_W = 4;

  logic              clk = 1'b0;
  logic              rstN;
  logic              cpuReq, cpuWe, cpuWord;
  logic [15:0]       cpuAddr, cpuWdata, cpuRdata;
  logic              bankWrEn;
  logic [BANK_W-1:0] bankNew, bankOld;
  logic [1:0]        region;
  logic              memReq, memWe, memWord;
  logic [BANK_W+15:0] memAddr;
  logic [15:0]       memWdata, memRdata;
  logic              rxValid;
  logic [7:0]        rxByte;
  logic              txReady, txValid;
  logic [7:0]        txByte;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  banked_addr_decoder #(.BANK_W(BANK_W)) u_dut (.*);

  // {addr, word, expected region, expected memReq}
  localparam int NV = 9;
  localparam logic [19:0] VECS [NV] = '{
    {16'h0000, 1'b1, 2'd0, 1'b1},
    {16'hFCFE, 1'b1, 2'd0, 1'b1},
    {16'hFCFF, 1'b0, 2'd0, 1'b1},
    {16'hFD00, 1'b1, 2'd1, 1'b1},
    {16'hFDFF, 1'b0, 2'd1, 1'b1},
    {16'hFE00, 1'b1, 2'd2, 1'b0},
    {16'hFE80, 1'b0, 2'd2, 1'b0},
    {16'hFF00, 1'b1, 2'd3, 1'b1},
    {16'hFFFF, 1'b0, 2'd3, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    cpuReq = 0; cpuWe = 0; cpuWord = 0; cpuAddr = 16'h0000; cpuWdata = 16'h0000;
    bankWrEn = 0; rxValid = 0;
  endtask

  task automatic access(input logic we, input logic word, input logic [15:0] a, input logic [15:0] d);
    cpuReq = 1; cpuWe = we; cpuWord = word; cpuAddr = a; cpuWdata = d;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
      summary();
    end
  end

  initial begin
    idle();
    rstN = 0; bankNew = '0; memRdata = 16'h0000; rxByte = 8'h00; txReady = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;

    // reset state: R3, R6, R9
    #1;
    chk("R3 reset bank", bankOld, 0);
    chk("R9 reset txValid", txValid, 0);
    access(0, 0, 16'hFE01, 0); #1;
    chk("R6 reset status", cpuRdata, 16'h0002);

    // bank switching: R3
    @(negedge clk); idle(); bankWrEn = 1; bankNew = 4'h5; #1;
    chk("R3 old bank before load", bankOld, 0);
    @(negedge clk); bankNew = 4'h9; #1;
    chk("R3 previous bank shown", bankOld, 5);
    @(negedge clk); bankNew = 4'h5; #1;
    chk("R3 bank loaded", bankOld, 9);
    @(negedge clk); idle(); #1;
    chk("R3 bank restored", bankOld, 5);

    // decode table: R1, R2, R4, R11
    for (int i = 0; i < NV; i++) begin
      logic [15:0] a;
      logic        w;
      logic [1:0]  rg;
      logic        mr;
      {a, w, rg, mr} = VECS[i];
      @(negedge clk); access(0, w, a, 0); #1;
      chk("R1 region", region, rg);
      chk("R11 memReq", memReq, mr);
      chk("R5 memWord", memWord, w && mr);
      if (mr) chk("R2 ext address", memAddr, {(rg == 2'd0) ? 4'h5 : 4'h0, a});
    end

    // memory data paths: R5, R11
    @(negedge clk); memRdata = 16'hABCD; access(0, 1, 16'h1234, 0); #1;
    chk("R5 word read big-endian", cpuRdata, 16'hABCD);
    chk("R11 read no memWe", memWe, 0);
    access(0, 0, 16'h1235, 0); #1;
    chk("R5 byte read", cpuRdata, 16'h00CD);
    access(1, 1, 16'h2000, 16'h1357); #1;
    chk("R5 word write data", memWdata, 16'h1357);
    chk("R11 memWe", memWe, 1);
    access(1, 0, 16'h2001, 16'h2468); #1;
    chk("R5 byte write data", memWdata, 16'h0068);

    // io forced byte and unused addresses: R4, R10
    memRdata = 16'hFFFF; access(0, 1, 16'hFE80, 0); #1;
    chk("R10 unused io read", cpuRdata, 16'h0000);
    chk("R4 io no memReq", memReq, 0);

    // receive: R7, R8
    @(negedge clk); idle(); rxValid = 1; rxByte = 8'h5A;
    @(negedge clk); rxByte = 8'h77; access(0, 0, 16'hFE01, 0); #1;
    chk("R7 ready after capture", cpuRdata, 16'h0003);
    @(negedge clk); idle(); access(0, 1, 16'hFE00, 0); #1;
    chk("R7 second byte ignored", cpuRdata, 16'h005A);
    chk("R4 io word read upper zero", cpuRdata[15:8], 8'h00);
    @(negedge clk); idle(); access(0, 0, 16'hFE01, 0); #1;
    chk("R8 ready cleared by read", cpuRdata, 16'h0002);

    // transmit: R9, R10
    @(negedge clk); idle(); txReady = 1; access(1, 1, 16'hFE00, 16'hBEEF);
    @(negedge clk); idle(); #1;
    chk("R9 txValid pulse", txValid, 1);
    chk("R9 txByte low byte", txByte, 8'hEF);
    @(negedge clk); #1;
    chk("R9 single pulse", txValid, 0);
    txReady = 0; access(1, 0, 16'hFE00, 16'h0042);
    @(negedge clk); idle(); #1;
    chk("R9 write ignored when busy", txValid, 0);
    txReady = 1; access(1, 0, 16'hFE05, 16'h0011);
    @(negedge clk); idle(); #1;
    chk("R10 unused io write no tx", txValid, 0);
    access(1, 0, 16'hFE01, 16'h00FF);
    @(negedge clk); idle(); access(0, 0, 16'hFE01, 0); #1;
    chk("R10 status write no effect", cpuRdata, 16'h0002);
    chk("R10 status write no tx", txValid, 0);

    @(negedge clk); idle();
    done = 1'b1;
    summary();
  end

endmodule